// File: doc/BRIEF.md
# Hashed Page Table Walker

This block turns a 32-bit effective address into a physical address. It searches a hashed page table held in ordinary memory. A requester hands it one address and an access kind. The walker then picks a virtual segment identifier from a bank of sixteen segment registers and hashes it with the page index to find a 64-byte group of eight two-word page-table entries. It reads the entries one at a time over a 32-bit word memory port.

If no entry in the first group matches, the walker repeats the scan in a second group found from the inverted hash. On a match it reads the entry's second word, which holds the real page number. For a read or a write it sets the referenced or changed status bit in that word and stores the word back. It then reports done with found and the physical address. At the same time it pulses a fill strobe so that a translation cache beside it can keep the page pair.

A miss in both groups ends with done and found low. Permission checks and fault signalling are left to the logic around the walker.

Top module: `pt_walker`

## Requirements
- R1: The segment register used is the one numbered by effective address bits 31:28. Each register in the bank is 24 bits wide, with register n at bank bits n*24+23 down to n*24.
- R2: The first group's byte address is ((vsid XOR zero-extended ea[27:12]) AND mask) * 64 OR table base. The mask is (size field << 10) OR 0x3FF.
- R3: Within a group the walker reads the first word of each entry in slot order 0 to 7. Entry k starts at group + 8*k. Every memory address is word aligned.
- R4: An entry matches only when all of these hold: first word bit 31 (valid) is 1, bits 30:7 equal the vsid, bits 5:0 equal ea[27:22], and bit 6 (hash select) is 0 in the first group or 1 in the second group.
- R5: After eight misses in the first group, the walker scans the group addressed with the one's complement of the 24-bit hash in place of the hash.
- R6: On a match the walker reads the second word at entry + 4. It then pulses done with found = 1 and phys_addr = {word[31:12], ea[11:0]}.
- R7: On a match, a read (acc 0) writes the second word back to entry + 4 with bit 8 set, and a write (acc 1) writes it back with bit 7 set. All other bits are left unchanged.
- R8: A no-update access (acc 2) or a fetch (acc 3) causes no memory write.
- R9: If both groups miss after sixteen entry reads, done pulses with found = 0 and fill_valid = 0.
- R10: A memory request stays asserted with a stable address and direction until mem_req_ready. No new request is issued while a read response is outstanding.
- R11: fill_valid pulses together with done on a hit, carrying fill_vpage = ea[31:12] and fill_ppage = the real page number.
- R12: After reset req_ready is 1 and done is 0. req_ready is 1 only while the walker is idle, and done lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request taken this cycle |
| req_ea | input | 32 | Effective address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 no-update, 3 fetch |
| seg_bank | input | 384 | Sixteen 24-bit segment identifiers |
| tbl_base | input | 32 | Page table base address |
| tbl_size | input | 9 | Table size field for the hash mask |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word byte address |
| mem_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| done | output | 1 | Walk finished, one-cycle pulse |
| found | output | 1 | Walk hit, valid with done |
| phys_addr | output | 32 | Physical address, valid with done and found |
| fill_valid | output | 1 | Translation cache fill strobe |
| fill_vpage | output | 20 | Virtual page for the fill |
| fill_ppage | output | 20 | Physical page for the fill |

## Verification
Some rules hold on every cycle, and the assertions check those at all times. They cover the memory handshake: a request held until accepted, and none issued while a response is pending. They also cover write-backs: these only go to the second word, only for read and write accesses, and a read's write-back carries bit 8. The remaining rules are the one-cycle done pulse, the fill strobe appearing only with a hit, and the page offset passing through to the physical address. The hash arithmetic, the slot and group order, the match rule with its decoy entries, and the exact status word written back can only be shown by the bench scenarios. Each of those scenarios compares every memory operation and every result against a model built from the requirements.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int ADDR_W  = 32;
  localparam int VSID_W  = 24;
  localparam int PGIDX_W = 16;
  localparam int API_W   = 6;
  localparam int OFS_W   = 12;
  localparam int RPN_W   = 20;

  localparam int W0_VALID = 31;
  localparam int W0_HSEL  = 6;
  localparam int W1_REF   = 8;
  localparam int W1_CHG   = 7;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_NOUPD = 2'd2,
    ACC_FETCH = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD0,
    S_W0,
    S_RD1,
    S_W1,
    S_WR,
    S_DONE
  } walk_st_e;

  // mask from the table size field, already zero-extended to 32 bits
  function automatic logic [ADDR_W-1:0] size_to_mask(input logic [ADDR_W-1:0] field);
    return (field << 10) | 32'h0000_03FF;
  endfunction

  function automatic logic [VSID_W-1:0] hash_of(input logic [VSID_W-1:0] vsid,
                                                input logic [PGIDX_W-1:0] pg,
                                                input logic second);
    logic [VSID_W-1:0] h;
    h = vsid ^ {{(VSID_W-PGIDX_W){1'b0}}, pg};
    return second ? ~h : h;
  endfunction

  function automatic logic [ADDR_W-1:0] group_of(input logic [VSID_W-1:0] hash,
                                                 input logic [ADDR_W-1:0] mask,
                                                 input logic [ADDR_W-1:0] base,
                                                 input int unsigned shift);
    logic [ADDR_W-1:0] wide;
    wide = {{(ADDR_W-VSID_W){1'b0}}, hash} & mask;
    return (wide << shift) | base;
  endfunction
endpackage

// File: rtl/ptw_seg_select.sv
module ptw_seg_select #(
  parameter int NUM_SEG = 16,
  parameter int VSID_W  = 24,
  localparam int SEL_W  = $clog2(NUM_SEG)
) (
  input  logic [NUM_SEG*VSID_W-1:0] bank,
  input  logic [SEL_W-1:0]          sel,
  output logic [VSID_W-1:0]         vsid
);
  logic [VSID_W-1:0] regs [NUM_SEG];

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_unpack
    assign regs[g] = bank[g*VSID_W +: VSID_W];
  end

  assign vsid = regs[sel];
endmodule

// File: rtl/ptw_group_addr.sv
module ptw_group_addr
  import ptw_pkg::*;
#(
  parameter int ENT_PER_GRP = 8,
  localparam int GRP_SHIFT  = $clog2(ENT_PER_GRP) + 3
) (
  input  logic [VSID_W-1:0]  vsid,
  input  logic [PGIDX_W-1:0] pg,
  input  logic [ADDR_W-1:0]  mask,
  input  logic [ADDR_W-1:0]  base,
  input  logic               second,
  output logic [ADDR_W-1:0]  grp_addr
);
  logic [VSID_W-1:0] hash;

  always_comb begin
    hash     = hash_of(vsid, pg, second);
    grp_addr = group_of(hash, mask, base, GRP_SHIFT);
  end
endmodule

// File: rtl/ptw_pte_match.sv
module ptw_pte_match
  import ptw_pkg::*;
(
  input  logic [31:0]       word0,
  input  logic [VSID_W-1:0] vsid,
  input  logic [API_W-1:0]  api,
  input  logic              second,
  output logic              hit
);
  logic valid_ok, vsid_ok, api_ok, hsel_ok;

  always_comb begin
    valid_ok = word0[W0_VALID];
    vsid_ok  = (word0[W0_VALID-1 -: VSID_W] == vsid);
    api_ok   = (word0[API_W-1:0] == api);
    hsel_ok  = (word0[W0_HSEL] == second);
    hit      = valid_ok && vsid_ok && api_ok && hsel_ok;
  end
endmodule

// File: rtl/ptw_status_merge.sv
module ptw_status_merge
  import ptw_pkg::*;
(
  input  logic [31:0] word1,
  input  acc_e        acc,
  output logic [31:0] merged,
  output logic        need_wr
);
  always_comb begin
    merged  = word1;
    need_wr = 1'b0;
    case (acc)
      ACC_READ: begin
        merged[W1_REF] = 1'b1;
        need_wr        = 1'b1;
      end
      ACC_WRITE: begin
        merged[W1_CHG] = 1'b1;
        need_wr        = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int SIZE_W      = 9,
  parameter int ENT_PER_GRP = 8,
  localparam int NUM_SEG    = 16,
  localparam int IDX_W      = $clog2(ENT_PER_GRP)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [31:0]               req_ea,
  input  logic [1:0]                req_acc,
  input  logic [NUM_SEG*VSID_W-1:0] seg_bank,
  input  logic [31:0]               tbl_base,
  input  logic [SIZE_W-1:0]         tbl_size,
  output logic                      mem_req_valid,
  input  logic                      mem_req_ready,
  output logic                      mem_we,
  output logic [31:0]               mem_addr,
  output logic [31:0]               mem_wdata,
  input  logic                      mem_rsp_valid,
  input  logic [31:0]               mem_rdata,
  output logic                      done,
  output logic                      found,
  output logic [31:0]               phys_addr,
  output logic                      fill_valid,
  output logic [19:0]               fill_vpage,
  output logic [19:0]               fill_ppage
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENT_PER_GRP - 1);

  walk_st_e          st;
  logic [31:0]       ea_q;
  acc_e              acc_q;
  logic [VSID_W-1:0] vsid_q;
  logic [31:0]       mask_q, base_q;
  logic              sec_q;
  logic [IDX_W-1:0]  idx_q;
  logic [31:0]       w1_q;
  logic [RPN_W-1:0]  rpn_q;
  logic              found_q;

  logic [VSID_W-1:0] vsid_sel;
  logic [31:0]       grp_addr, ent_addr;
  logic              ent_hit;
  logic [31:0]       merged;
  logic              need_wr;

  // named events for the checker
  logic ev_accept, ev_w0_rsp, ev_hit, ev_grp_end, ev_miss, ev_w1_rsp, ev_mem_fire, wait_rsp;

  ptw_seg_select #(.NUM_SEG(NUM_SEG), .VSID_W(VSID_W)) u_seg (
    .bank (seg_bank),
    .sel  (req_ea[31:28]),
    .vsid (vsid_sel)
  );

  ptw_group_addr #(.ENT_PER_GRP(ENT_PER_GRP)) u_grp (
    .vsid     (vsid_q),
    .pg       (ea_q[27:12]),
    .mask     (mask_q),
    .base     (base_q),
    .second   (sec_q),
    .grp_addr (grp_addr)
  );

  ptw_pte_match u_match (
    .word0  (mem_rdata),
    .vsid   (vsid_q),
    .api    (ea_q[27:22]),
    .second (sec_q),
    .hit    (ent_hit)
  );

  ptw_status_merge u_merge (
    .word1   (mem_rdata),
    .acc     (acc_q),
    .merged  (merged),
    .need_wr (need_wr)
  );

  assign ent_addr    = grp_addr + {{(32-IDX_W-3){1'b0}}, idx_q, 3'b000};

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_RD0) || (st == S_RD1) || (st == S_WR);
  assign mem_we        = (st == S_WR);
  assign mem_addr      = (st == S_RD0) ? ent_addr : (ent_addr | 32'h4);
  assign mem_wdata     = w1_q;

  assign ev_accept   = req_valid && req_ready;
  assign ev_w0_rsp   = (st == S_W0) && mem_rsp_valid;
  assign ev_hit      = ev_w0_rsp && ent_hit;
  assign ev_grp_end  = ev_w0_rsp && !ent_hit && (idx_q == LAST_IDX);
  assign ev_miss     = ev_grp_end && sec_q;
  assign ev_w1_rsp   = (st == S_W1) && mem_rsp_valid;
  assign ev_mem_fire = mem_req_valid && mem_req_ready;
  assign wait_rsp    = (st == S_W0) || (st == S_W1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ea_q    <= '0;
      acc_q   <= ACC_READ;
      vsid_q  <= '0;
      mask_q  <= '0;
      base_q  <= '0;
      sec_q   <= 1'b0;
      idx_q   <= '0;
      w1_q    <= '0;
      rpn_q   <= '0;
      found_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (ev_accept) begin
            ea_q    <= req_ea;
            acc_q   <= acc_e'(req_acc);
            vsid_q  <= vsid_sel;
            mask_q  <= size_to_mask({{(32-SIZE_W){1'b0}}, tbl_size});
            base_q  <= tbl_base;
            sec_q   <= 1'b0;
            idx_q   <= '0;
            found_q <= 1'b0;
            st      <= S_RD0;
          end
        end
        S_RD0: if (ev_mem_fire) st <= S_W0;
        S_W0: begin
          if (ev_hit) begin
            st <= S_RD1;
          end else if (ev_miss) begin
            found_q <= 1'b0;
            st      <= S_DONE;
          end else if (ev_grp_end) begin
            sec_q <= 1'b1;
            idx_q <= '0;
            st    <= S_RD0;
          end else if (ev_w0_rsp) begin
            idx_q <= idx_q + 1'b1;
            st    <= S_RD0;
          end
        end
        S_RD1: if (ev_mem_fire) st <= S_W1;
        S_W1: begin
          if (ev_w1_rsp) begin
            w1_q    <= merged;
            rpn_q   <= mem_rdata[31:OFS_W];
            found_q <= 1'b1;
            st      <= need_wr ? S_WR : S_DONE;
          end
        end
        S_WR:   if (ev_mem_fire) st <= S_DONE;
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign done       = (st == S_DONE);
  assign found      = done && found_q;
  assign phys_addr  = found ? {rpn_q, ea_q[OFS_W-1:0]} : 32'h0;
  assign fill_valid = done && found_q;
  assign fill_vpage = ea_q[31:OFS_W];
  assign fill_ppage = rpn_q;
endmodule

// File: rtl/ptw_chk.sv
module ptw_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        done,
  input logic        found,
  input logic        fill_valid,
  input logic [31:0] phys_addr,
  input logic [31:0] ea_q,
  input logic [1:0]  acc_q,
  input logic        wait_rsp
);
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    wait_rsp |-> !mem_req_valid); // R10
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr) && $stable(mem_we)); // R10
  AST_READ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_we |-> mem_addr[1:0] == 2'b00); // R3
  AST_WR_ONLY_UPDATING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_we |-> acc_q == 2'd0 || acc_q == 2'd1); // R8
  AST_WR_SECOND_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_we |-> mem_addr[2:0] == 3'b100); // R7
  AST_READ_SETS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_we && acc_q == 2'd0 |-> mem_wdata[8]); // R7
  AST_WRITE_SETS_CHG: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_we && acc_q == 2'd1 |-> mem_wdata[7]); // R7
  AST_PA_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> phys_addr[11:0] == ea_q[11:0]); // R6
  AST_FILL_WITH_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> done && found); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R12
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid && !done); // R12
endmodule

bind pt_walker ptw_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_we        (mem_we),
  .mem_addr      (mem_addr),
  .mem_wdata     (mem_wdata),
  .done          (done),
  .found         (found),
  .fill_valid    (fill_valid),
  .phys_addr     (phys_addr),
  .ea_q          (ea_q),
  .acc_q         (acc_q),
  .wait_rsp      (wait_rsp)
);

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_ea = '0;
  logic [1:0]  req_acc = '0;
  logic [383:0] seg_bank;
  logic [31:0] tbl_base = '0;
  logic [8:0]  tbl_size = '0;
  logic        mem_req_valid, mem_we;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        done, found, fill_valid;
  logic [31:0] phys_addr;
  logic [19:0] fill_vpage, fill_ppage;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_ea(req_ea), .req_acc(req_acc), .seg_bank(seg_bank), .tbl_base(tbl_base),
    .tbl_size(tbl_size), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rdata(mem_rdata), .done(done), .found(found),
    .phys_addr(phys_addr), .fill_valid(fill_valid), .fill_vpage(fill_vpage),
    .fill_ppage(fill_ppage)
  );

  logic [23:0] seg [16];
  always_comb for (int i = 0; i < 16; i++) seg_bank[i*24 +: 24] = seg[i];

  int checks = 0;
  int errors = 0;
  int n_done = 0;
  bit finished = 1'b0;

  typedef struct { bit we; logic [31:0] addr; logic [31:0] data; string tag; } mop_t;
  typedef struct { bit hit; logic [31:0] pa; logic [19:0] vp; string tag; } res_t;
  mop_t op_q[$];
  res_t res_q[$];

  logic [31:0] mem [logic [31:0]];
  logic [3:0]  rdy_cnt = '0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: ready stalls one cycle in four, read data one cycle after acceptance
  always @(posedge clk) begin
    rdy_cnt       <= rdy_cnt + 1'b1;
    mem_req_ready <= (rdy_cnt[1:0] != 2'b10);
    mem_rsp_valid <= 1'b0;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (mem_we) mem[mem_addr] = mem_wdata;
      else begin
        mem_rsp_valid <= 1'b1;
        mem_rdata     <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
      end
    end
  end

  // monitor: compares memory traffic and results against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req_valid && mem_rsp_valid)
        check(1'b0, "R10 request during pending response", 64'(mem_addr), 64'h0);
      if (mem_req_valid && mem_req_ready) begin
        if (op_q.size() == 0) begin
          check(1'b0, mem_we ? "R8 unexpected write" : "R3 unexpected read", 64'(mem_addr), 64'h0);
        end else begin
          mop_t e;
          e = op_q.pop_front();
          check(mem_we == e.we && mem_addr == e.addr, e.tag, {31'h0, mem_we, mem_addr}, {31'h0, e.we, e.addr});
          if (e.we) check(mem_wdata == e.data, "R7 write data", 64'(mem_wdata), 64'(e.data));
        end
      end
      if (done) begin
        res_t r;
        if (res_q.size() == 0) begin
          check(1'b0, "R12 unexpected done", 64'(found), 64'h0);
        end else begin
          r = res_q.pop_front();
          check(found == r.hit, {r.tag, " found"}, 64'(found), 64'(r.hit));
          check(fill_valid == r.hit, "R11 fill strobe", 64'(fill_valid), 64'(r.hit));
          if (r.hit) begin
            check(phys_addr == r.pa, "R6 physical address", 64'(phys_addr), 64'(r.pa));
            check(fill_vpage == r.vp && fill_ppage == r.pa[31:12], "R11 fill pages",
                  {24'h0, fill_vpage, fill_ppage}, {24'h0, r.vp, r.pa[31:12]});
          end
          check(op_q.size() == 0, "R3 missing memory operations", 64'(op_q.size()), 64'h0);
        end
        n_done++;
      end
    end
  end

  function automatic logic [31:0] ref_group(input logic [23:0] vsid, input logic [15:0] pg, input bit second);
    logic [23:0] h;
    logic [31:0] m;
    h = vsid ^ {8'h00, pg};
    if (second) h = ~h;
    m = {13'h0, tbl_size, 10'h3FF};
    return tbl_base | (({8'h00, h} & m) * 32'd64);
  endfunction

  function automatic logic [31:0] pte0(input bit v, input logic [23:0] vsid, input bit h, input logic [5:0] api);
    return {v, vsid, h, api};
  endfunction

  task automatic push_op(input bit we, input logic [31:0] a, input logic [31:0] d, input string tag);
    mop_t e;
    e.we = we; e.addr = a; e.data = d; e.tag = tag;
    op_q.push_back(e);
  endtask

  // driver: plants the hit entry, queues the expected traffic and result, issues the request
  task automatic walk(input logic [31:0] ea, input logic [1:0] acc, input bit hit,
                      input bit hsec, input int slot, input logic [31:0] w1, input string tag);
    logic [23:0] vsid;
    logic [31:0] g0, g1, gh, expw;
    int np, prev;
    res_t r;
    vsid = seg[ea[31:28]];
    g0 = ref_group(vsid, ea[27:12], 1'b0);
    g1 = ref_group(vsid, ea[27:12], 1'b1);
    gh = (hsec ? g1 : g0) + 32'(slot * 8);
    if (hit) begin
      mem[gh]     = pte0(1'b1, vsid, hsec, ea[27:22]);
      mem[gh + 4] = w1;
    end
    np = (hit && !hsec) ? slot + 1 : 8;
    for (int i = 0; i < np; i++) push_op(1'b0, g0 + 32'(i * 8), 32'h0, i == 0 ? "R2 first group" : "R3 slot order");
    if (!hit || hsec) begin
      np = hit ? slot + 1 : 8;
      for (int i = 0; i < np; i++) push_op(1'b0, g1 + 32'(i * 8), 32'h0, "R5 second group");
    end
    expw = w1;
    if (hit) begin
      push_op(1'b0, gh + 4, 32'h0, "R6 second word read");
      if (acc == 2'd0) begin expw = w1 | 32'h100; push_op(1'b1, gh + 4, expw, "R7 referenced write-back"); end
      if (acc == 2'd1) begin expw = w1 | 32'h080; push_op(1'b1, gh + 4, expw, "R7 changed write-back"); end
    end
    r.hit = hit; r.pa = {w1[31:12], ea[11:0]}; r.vp = ea[31:12]; r.tag = tag;
    res_q.push_back(r);

    prev = n_done;
    @(negedge clk);
    req_ea = ea; req_acc = acc; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R12 busy during walk", 64'(req_ready), 64'h0);
    while (n_done == prev) @(negedge clk);
    check(done == 1'b0, "R12 done one cycle", 64'(done), 64'h0);
    if (hit) check(mem[gh + 4] == expw, acc[1] ? "R8 entry unchanged" : "R7 entry updated",
                   64'(mem[gh + 4]), 64'(expw));
  endtask

  initial begin
    for (int i = 0; i < 16; i++) seg[i] = 24'h100000 + 24'(i * 24'h1111);
    seg[1] = 24'h0ABCDE; seg[3] = 24'hC0FFEE; seg[5] = 24'h123456;
    seg[7] = 24'h000001; seg[15] = 24'hFFFFFF; seg[9] = 24'h5A5A5A;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(req_ready == 1'b1, "R12 reset ready", 64'(req_ready), 64'h1);
    check(done == 1'b0 && fill_valid == 1'b0, "R12 reset done", {62'h0, done, fill_valid}, 64'h0);
    check(mem_req_valid == 1'b0, "R12 reset memory idle", 64'(mem_req_valid), 64'h0);
    rst_n = 1'b1;

    // read hit, first group, slot 0
    tbl_base = 32'h0010_0000; tbl_size = 9'h000;
    mem.delete();
    walk(32'h1234_5678, 2'd0, 1'b1, 1'b0, 0, 32'h0001_2002, "R6 read hit");

    // R1: segment 3, write hit in slot 5, larger mask
    tbl_base = 32'h0200_0000; tbl_size = 9'h003;
    mem.delete();
    walk(32'h3FF0_1ABC, 2'd1, 1'b1, 1'b0, 5, 32'hABCDE105, "R1 segment select write hit");

    // R4 and R9: decoys only, miss in both groups
    tbl_base = 32'h0010_0000; tbl_size = 9'h000;
    mem.delete();
    begin
      logic [31:0] g0, g1;
      logic [23:0] v;
      logic [5:0]  api;
      v = seg[5]; api = 6'h2A ^ 6'h00;
      api = 6'b101010 & 6'h3F;
      api = 32'h5ABC_D123 >> 22;
      g0 = ref_group(v, 16'hABCD, 1'b0);
      g1 = ref_group(v, 16'hABCD, 1'b1);
      mem[g0 + 8]  = pte0(1'b1, v, 1'b1, api);
      mem[g0 + 24] = pte0(1'b0, v, 1'b0, api);
      mem[g0 + 48] = pte0(1'b1, v, 1'b0, api ^ 6'h01);
      mem[g1 + 16] = pte0(1'b1, v, 1'b0, api);
      mem[g1 + 56] = pte0(1'b1, v ^ 24'h1, 1'b1, api);
      walk(32'h5ABC_D123, 2'd0, 1'b0, 1'b0, 0, 32'h0, "R4 R9 decoys miss");
    end

    // R5: fetch hit in second group slot 4 behind a primary decoy
    mem.delete();
    begin
      logic [31:0] g0;
      g0 = ref_group(seg[7], 16'h0000, 1'b0);
      mem[g0 + 32] = pte0(1'b1, seg[7], 1'b1, 6'h00);
      walk(32'h7000_0FFF, 2'd3, 1'b1, 1'b1, 4, 32'h7654_3000, "R5 fetch second group");
    end

    // R8: no-update hit in the last slot of the first group
    tbl_base = 32'h0400_0000; tbl_size = 9'h010;
    mem.delete();
    walk(32'hF000_1000, 2'd2, 1'b1, 1'b0, 7, 32'h1111_1180, "R8 no-update last slot");

    // write hit in second group slot 0 with the widest size field
    tbl_base = 32'h8000_0000; tbl_size = 9'h1FF;
    mem.delete();
    walk(32'h9FED_CBA9, 2'd1, 1'b1, 1'b1, 0, 32'hFEDCB000, "R2 R5 wide mask write");

    // read hit where the referenced bit is already set
    tbl_base = 32'h0300_0000; tbl_size = 9'h001;
    mem.delete();
    walk(32'h1000_0004, 2'd0, 1'b1, 1'b0, 2, 32'h0ABC_D1FF, "R7 read already referenced");

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule